// File: doc/BRIEF.md
# Differential Clock Output Stop Controller

This block decides, pair by pair, whether each of eight differential clock outputs toggles, parks at a fixed level, or floats. Every pair is modelled as a true leg and a complement leg, and each leg has its own drive enable. The block runs on one clock. An internal phase register divides that clock by two to form the output clock. The true leg follows the phase and the complement leg follows its inverse.

Two requests arrive without any timing relation to the clock: one stops the outputs and one powers them down. A request is first synchronised. It is then accepted only when it holds the same level at two consecutive rising edges of the complement clock, and this rule applies both when the request rises and when it falls. A strap pin is captured while reset is high. The strap sets whether the two requests and the eight per-pair enable pins are active-high or active-low. Register inputs from elsewhere in the chip supply four settings: whether a stopped pair floats, whether a powered-down pair floats, a register enable for each pair, and whether each pair is stoppable or free-running.

All pairs change state together, and only at the clock edge where the complement leg falls. A parked pair is therefore always left holding a completed high level on its true leg. When it restarts, it opens with a full high phase.

Top module: `diffclk_stop_ctrl`

## Requirements
- R1: While reset is high, the strap level is captured and held. After reset every pair is in the running state, the phase starts low, and all leg drive enables read 0 until the enable pins have passed through the two-stage synchroniser.
- R2: Strap captured as 0 makes the stop, power-down and per-pair enable pins active-high. Strap captured as 1 makes all of them active-low.
- R3: A request changes its accepted state only when its synchronised level is equal at two consecutive complement-clock rising edges. These are the clock edges where the phase is 1. A request held for a single clock cycle has no effect.
- R4: While a stop is accepted, a pair whose stoppable bit is 0 keeps toggling.
- R5: While a stop is accepted, a pair whose stoppable bit is 1 parks at the next complement falling edge, after its true leg has made its rising transition. With the stop-float bit at 0, the true leg is driven 1 and the complement leg is undriven and reads 0. With the stop-float bit at 1, both legs are undriven and read 0.
- R6: When a stop is released, all stopped pairs resume at the same clock edge. Each resumes with its true leg high. The first falling edge of the true leg arrives between 2 and 6 output periods after the pin change.
- R7: An accepted power-down parks every pair at the next complement falling edge. With the power-down-float bit at 0, the true leg is driven 1 and the complement leg is undriven. With the power-down-float bit at 1, both legs are undriven.
- R8: When power-down and stop are both accepted, every pair shows the power-down drive and not the stop drive.
- R9: A pair is enabled only when its synchronised enable pin is active and its register enable bit is 1. A pair that is not enabled has both legs undriven, with value 0.
- R10: Whenever both legs of a pair are driven, they carry opposite values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the output clock is this clock divided by two |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| polarity_strap | input | 1 | 0 = control pins active-high, 1 = control pins active-low |
| stop_pin | input | 1 | Asynchronous stop request |
| pwrdn_pin | input | 1 | Asynchronous power-down request |
| oe_pin | input | PAIRS | Per-pair enable pins (asynchronous) |
| cfg_stop_float | input | 1 | 1 = stopped pairs float both legs |
| cfg_pwrdn_float | input | 1 | 1 = powered-down pairs float both legs |
| cfg_pair_en | input | PAIRS | Register enable for each pair |
| cfg_stoppable | input | PAIRS | 1 = the pair obeys stop, 0 = the pair runs freely |
| clk_true | output | PAIRS | True leg value (0 when undriven) |
| clk_comp | output | PAIRS | Complement leg value (0 when undriven) |
| true_oe | output | PAIRS | Drive enable of each true leg |
| comp_oe | output | PAIRS | Drive enable of each complement leg |

## Verification
Stop and power-down can both be accepted and both act at the same shared complement falling edge. The bench holds both requests active with the stop-float bit set and the power-down-float bit clear. It then checks that each stoppable pair shows the driven-high true leg of power-down and not the floating legs of stop. A second overlap is a stop release that occurs while pairs are disabled or free-running. A behavioural model, updated every cycle, predicts each leg and each drive enable. The bench compares the model against the outputs after every edge and also makes targeted checks on latency and polarity.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    parameter int DEFAULT_PAIRS = 8;

    typedef enum logic [1:0] {
        PAIR_RUN   = 2'd0,
        PAIR_HALT  = 2'd1,
        PAIR_SLEEP = 2'd2
    } pair_mode_e;

    typedef struct packed {
        logic t_val;
        logic t_oe;
        logic c_val;
        logic c_oe;
    } leg_drive_t;

    function automatic logic apply_sense(input logic pin, input logic low_active);
        return pin ^ low_active;
    endfunction

    function automatic pair_mode_e next_mode(input logic pd_ok, input logic stop_ok,
                                             input logic stoppable);
        pair_mode_e m;
        if (pd_ok)                      m = PAIR_SLEEP;
        else if (stop_ok && stoppable)  m = PAIR_HALT;
        else                            m = PAIR_RUN;
        return m;
    endfunction

    function automatic leg_drive_t leg_drive(input pair_mode_e st, input logic en,
                                             input logic ph, input logic halt_float,
                                             input logic sleep_float);
        leg_drive_t d;
        d = '0;
        if (en) begin
            case (st)
                PAIR_RUN: begin
                    d.t_val = ph;
                    d.t_oe  = 1'b1;
                    d.c_val = ~ph;
                    d.c_oe  = 1'b1;
                end
                PAIR_HALT: begin
                    if (!halt_float) begin
                        d.t_val = 1'b1;
                        d.t_oe  = 1'b1;
                    end
                end
                PAIR_SLEEP: begin
                    if (!sleep_float) begin
                        d.t_val = 1'b1;
                        d.t_oe  = 1'b1;
                    end
                end
                default: d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         low_active,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import dsc_pkg::*;

    logic [W-1:0] s1, s2;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1[g] <= 1'b0;
                    s2[g] <= 1'b0;
                end else begin
                    s1[g] <= apply_sense(d[g], low_active);
                    s2[g] <= s1[g];
                end
            end
        end
    endgenerate

    assign q = s2;

endmodule

// File: rtl/dsc_debounce.sv
module dsc_debounce (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic lvl,
    output logic accepted
);
    logic smp;
    logic acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp   <= 1'b0;
            acc_q <= 1'b0;
        end else if (sample_en) begin
            smp <= lvl;
            if (lvl == smp) acc_q <= lvl;
        end
    end

    assign accepted = acc_q;

    // Accepted level moves only at a sample edge after two equal samples.
    assert_two_sample_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_q != $past(acc_q)) |-> ($past(sample_en) && ($past(lvl) == $past(smp))))
        else $error("R3: accepted level changed without two agreeing samples");

    assert_stable_between_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_en) |-> $stable(acc_q))
        else $error("R3: accepted level changed off a sample edge");

endmodule

// File: rtl/dsc_pair.sv
module dsc_pair
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic phase,
    input  logic pd_ok,
    input  logic stop_ok,
    input  logic stoppable,
    input  logic en,
    input  logic halt_float,
    input  logic sleep_float,
    output logic t_val,
    output logic t_oe,
    output logic c_val,
    output logic c_oe
);
    pair_mode_e st;
    leg_drive_t drv;

    always_ff @(posedge clk) begin
        if (rst)       st <= PAIR_RUN;
        else if (tick) st <= next_mode(pd_ok, stop_ok, stoppable);
    end

    always_comb drv = leg_drive(st, en, phase, halt_float, sleep_float);

    assign t_val = drv.t_val;
    assign t_oe  = drv.t_oe;
    assign c_val = drv.c_val;
    assign c_oe  = drv.c_oe;

    // State moves only at the complement falling edge (phase low before the edge).
    assert_shared_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (st != $past(st)) |-> !$past(phase))
        else $error("R6: pair state changed off the shared edge");

    assert_halt_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(st == PAIR_HALT) |-> $past(stop_ok && stoppable && !pd_ok))
        else $error("R5: pair halted without an accepted stop");

    assert_sleep_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && pd_ok) |=> (st == PAIR_SLEEP))
        else $error("R8: power-down did not take the pair");

    assert_free_run_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !pd_ok && !stoppable) |=> (st == PAIR_RUN))
        else $error("R4: free-running pair left the running state");

    assert_restart_high_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(st == PAIR_HALT) && (st == PAIR_RUN) && en) |-> (t_val && t_oe))
        else $error("R6: restart did not begin with a high true leg");

    assert_opposite_legs_R10: assert property (@(posedge clk) disable iff (rst)
        (t_oe && c_oe) |-> (t_val != c_val))
        else $error("R10: both legs driven to the same level");

endmodule

// File: rtl/diffclk_stop_ctrl.sv
module diffclk_stop_ctrl
    import dsc_pkg::*;
#(
    parameter int PAIRS = DEFAULT_PAIRS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             polarity_strap,
    input  logic             stop_pin,
    input  logic             pwrdn_pin,
    input  logic [PAIRS-1:0] oe_pin,
    input  logic             cfg_stop_float,
    input  logic             cfg_pwrdn_float,
    input  logic [PAIRS-1:0] cfg_pair_en,
    input  logic [PAIRS-1:0] cfg_stoppable,
    output logic [PAIRS-1:0] clk_true,
    output logic [PAIRS-1:0] clk_comp,
    output logic [PAIRS-1:0] true_oe,
    output logic [PAIRS-1:0] comp_oe
);
    localparam int SW       = PAIRS + 2;
    localparam int IDX_STOP = PAIRS;
    localparam int IDX_PD   = PAIRS + 1;

    logic          low_active_q;
    logic          phase;
    logic [SW-1:0] sync_q;
    logic          stop_ok, pd_ok;
    logic [PAIRS-1:0] pair_en;

    always_ff @(posedge clk) begin
        if (rst) low_active_q <= polarity_strap;
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    dsc_sync #(.W(SW)) i_sync (
        .clk        (clk),
        .rst        (rst),
        .low_active (low_active_q),
        .d          ({pwrdn_pin, stop_pin, oe_pin}),
        .q          (sync_q)
    );

    dsc_debounce i_deb_stop (
        .clk       (clk),
        .rst       (rst),
        .sample_en (phase),
        .lvl       (sync_q[IDX_STOP]),
        .accepted  (stop_ok)
    );

    dsc_debounce i_deb_pd (
        .clk       (clk),
        .rst       (rst),
        .sample_en (phase),
        .lvl       (sync_q[IDX_PD]),
        .accepted  (pd_ok)
    );

    assign pair_en = sync_q[PAIRS-1:0] & cfg_pair_en;

    genvar p;
    generate
        for (p = 0; p < PAIRS; p++) begin : g_pair
            dsc_pair i_pair (
                .clk         (clk),
                .rst         (rst),
                .tick        (~phase),
                .phase       (phase),
                .pd_ok       (pd_ok),
                .stop_ok     (stop_ok),
                .stoppable   (cfg_stoppable[p]),
                .en          (pair_en[p]),
                .halt_float  (cfg_stop_float),
                .sleep_float (cfg_pwrdn_float),
                .t_val       (clk_true[p]),
                .t_oe        (true_oe[p]),
                .c_val       (clk_comp[p]),
                .c_oe        (comp_oe[p])
            );
        end
    endgenerate

    // Strap is frozen once reset is released.
    assert_strap_held_R1: assert property (@(posedge clk) disable iff (rst)
        $stable(low_active_q))
        else $error("R1: strap capture changed outside reset");

    assert_undriven_low_R9: assert property (@(posedge clk) disable iff (rst)
        ((clk_true & ~true_oe) == '0) && ((clk_comp & ~comp_oe) == '0))
        else $error("R9: undriven leg reads nonzero");

endmodule

// File: tb/test_diffclk_stop_ctrl.sv
`timescale 1ns/1ps
module test_diffclk_stop_ctrl;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b0;
    logic stop_pin = 1'b0, pwrdn_pin = 1'b0;
    logic [N-1:0] oe_pin = '1;
    logic stop_float = 1'b0, pwrdn_float = 1'b0;
    logic [N-1:0] pair_en = '1;
    logic [N-1:0] stoppable = 8'h0F;
    logic [N-1:0] clk_true, clk_comp, true_oe, comp_oe;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    diffclk_stop_ctrl #(.PAIRS(N)) i_diffclk_stop_ctrl (
        .clk(clk), .rst(rst), .polarity_strap(strap),
        .stop_pin(stop_pin), .pwrdn_pin(pwrdn_pin), .oe_pin(oe_pin),
        .cfg_stop_float(stop_float), .cfg_pwrdn_float(pwrdn_float),
        .cfg_pair_en(pair_en), .cfg_stoppable(stoppable),
        .clk_true(clk_true), .clk_comp(clk_comp),
        .true_oe(true_oe), .comp_oe(comp_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: 0 running, 1 halted, 2 powered down.
    int  m_st[N];
    bit  m_inv, m_ph;
    bit  [N+1:0] m_s1, m_s2;
    bit  m_smp_pd, m_acc_pd, m_smp_sp, m_acc_sp;

    always @(posedge clk) begin
        bit was_rst;
        was_rst = rst;
        if (rst) begin
            m_inv = strap; m_ph = 0; m_s1 = '0; m_s2 = '0;
            m_smp_pd = 0; m_acc_pd = 0; m_smp_sp = 0; m_acc_sp = 0;
            for (int i = 0; i < N; i++) m_st[i] = 0;
        end else begin
            if (m_ph) begin
                if (m_s2[N+1] == m_smp_pd) m_acc_pd = m_s2[N+1];
                m_smp_pd = m_s2[N+1];
                if (m_s2[N] == m_smp_sp) m_acc_sp = m_s2[N];
                m_smp_sp = m_s2[N];
            end else begin
                for (int i = 0; i < N; i++)
                    m_st[i] = m_acc_pd ? 2 : ((m_acc_sp && stoppable[i]) ? 1 : 0);
            end
            m_s2 = m_s1;
            m_s1 = {pwrdn_pin, stop_pin, oe_pin} ^ {(N+2){m_inv}};
            m_ph = ~m_ph;
        end
        #1;
        if (!was_rst && !done) begin
            for (int i = 0; i < N; i++) begin
                bit en, et, eto, ec, eco, flt;
                string tag;
                en = m_s2[i] & pair_en[i];
                et = 0; eto = 0; ec = 0; eco = 0;
                if (!en) tag = "R9";
                else if (m_st[i] == 0) begin
                    et = m_ph; ec = ~m_ph; eto = 1; eco = 1;
                    tag = stoppable[i] ? "R10" : "R4";
                end else begin
                    flt = (m_st[i] == 1) ? stop_float : pwrdn_float;
                    tag = (m_st[i] == 1) ? "R5" : "R7";
                    if (!flt) begin et = 1; eto = 1; end
                end
                check({clk_true[i], true_oe[i], clk_comp[i], comp_oe[i]} == {et, eto, ec, eco},
                      tag, {clk_true[i], true_oe[i], clk_comp[i], comp_oe[i]},
                      {et, eto, ec, eco});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_neg(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset(input bit s);
        @(negedge clk);
        rst = 1; strap = s;
        wait_neg(4);
        rst = 0;
        strap = ~s; // strap moves after reset; must be ignored (R1)
    endtask

    initial begin
        int lat;
        logic a;
        do_reset(1'b0);
        // R1: enables still in synchroniser on first cycle
        @(posedge clk); #2;
        check(true_oe == 0 && comp_oe == 0, "R1", true_oe, 0);
        wait_neg(10);
        check(true_oe == '1 && comp_oe == '1, "R1", true_oe, 8'hFF);
        a = clk_true[0]; wait_neg(1);
        check(clk_true[0] != a, "R1", clk_true[0], !a);

        // R3: single-cycle stop pulse is ignored
        stop_pin = 1; wait_neg(1); stop_pin = 0;
        wait_neg(12);
        a = clk_true[0]; wait_neg(1);
        check(clk_true[0] != a && true_oe[0], "R3", clk_true[0], !a);

        // R4/R5: held stop, driven park
        stop_pin = 1; wait_neg(20);
        check(clk_true[3:0] == 4'hF && true_oe[3:0] == 4'hF && comp_oe[3:0] == 0,
              "R5", {clk_true[3:0], comp_oe[3:0]}, 8'hF0);
        a = clk_true[7]; wait_neg(1);
        check(clk_true[7] != a && comp_oe[7], "R4", clk_true[7], !a);

        // R6: release, measure latency to first falling true edge
        stop_pin = 0; lat = 0;
        while (clk_true[0] == 1'b1 && lat < 40) begin wait_neg(1); lat++; end
        check(lat >= 4 && lat <= 12, "R6", lat, 8);
        check(clk_true[3:0] == 4'h0 && true_oe[3:0] == 4'hF, "R6", clk_true[3:0], 0);

        // R5: floating stop
        stop_float = 1; stop_pin = 1; wait_neg(20);
        check(true_oe[3:0] == 0 && comp_oe[3:0] == 0 && clk_true[3:0] == 0, "R5", true_oe[3:0], 0);
        stop_pin = 0; wait_neg(20);

        // R7: power-down driven
        pwrdn_pin = 1; wait_neg(20);
        check(clk_true == '1 && true_oe == '1 && comp_oe == 0, "R7", {clk_true, comp_oe}, 16'hFF00);
        // R8: stop floating, power-down driven -> power-down drive wins
        stop_pin = 1; wait_neg(20);
        check(true_oe[3:0] == 4'hF && clk_true[3:0] == 4'hF, "R8", true_oe[3:0], 4'hF);
        pwrdn_float = 1; wait_neg(4);
        check(true_oe == 0 && comp_oe == 0, "R7", true_oe, 0);
        pwrdn_pin = 0; stop_pin = 0; pwrdn_float = 0; stop_float = 0; wait_neg(20);

        // R9: pin enable and register enable both needed
        oe_pin[5] = 0; pair_en[6] = 0; wait_neg(6);
        check(true_oe[5] == 0 && comp_oe[5] == 0, "R9", true_oe[5], 0);
        check(true_oe[6] == 0 && comp_oe[6] == 0 && true_oe[4], "R9", true_oe[6], 0);
        oe_pin[5] = 1; pair_en[6] = 1; wait_neg(6);

        // R2: strap 1 -> active-low pins
        stop_pin = 1; pwrdn_pin = 1; oe_pin = '0;
        do_reset(1'b1);
        wait_neg(12);
        check(true_oe == '1 && comp_oe == '1, "R2", true_oe, 8'hFF);
        a = clk_true[0]; wait_neg(1);
        check(clk_true[0] != a, "R2", clk_true[0], !a);
        stop_pin = 0; wait_neg(20);
        check(clk_true[3:0] == 4'hF && comp_oe[3:0] == 0, "R2", comp_oe[3:0], 0);
        stop_pin = 1; wait_neg(20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule